// File: doc/BRIEF.md
# Radix Selection Cost Evaluator

This block picks the radix for a mixed-radix FFT engine once, at start-up. Software or a boot sequencer presents a requested transform length and a weight, pulses `start`, and waits for `done`. The block then tries every integer radix that can apply. For each one it finds the smallest power of the radix that covers the request, counts the zero samples that power adds, and estimates the run time of a radix-r transform of that length. The cost is the padding plus the weighted run time. The radix with the lowest cost is returned, together with its padded length, its stage count, its padding and the cost itself.

All arithmetic is integer. The stage count comes from repeated multiplication, so no logarithm unit is needed. The non-integer factor r·sqrt(r) comes from a table that is computed when the design is elaborated. The search runs over many cycles, one candidate after another, because it runs only once and nothing waits on it.

The controller is a state machine with six states. ST_IDLE waits for `start`. It goes to ST_LOAD for a usable length, or straight to ST_DONE for a length below two. ST_LOAD resets the power accumulator for the current radix and always moves to ST_POWER. ST_POWER multiplies once per cycle. It goes to ST_COST when the power covers the request, or to ST_COMPARE when the next product would overflow. ST_COST waits for the three-stage cost pipeline and then moves to ST_COMPARE. ST_COMPARE keeps the candidate if it is strictly cheaper than the best so far. It returns to ST_LOAD with the next radix, or moves to ST_DONE after the last candidate. ST_DONE lasts one cycle and returns to ST_IDLE. Results and `done` are registered one cycle after ST_DONE.

Top module: `radix_cost_sel`

## Requirements
- R1: After reset, `done`, `busy`, `invalid`, `radix`, `padded_len`, `stages`, `pad_cnt` and `cost` are all zero.
- R2: For the chosen radix r, `stages` is the smallest M ≥ 1 with r^M ≥ n0. `padded_len` equals r^M, and `pad_cnt` equals `padded_len` − n0.
- R3: Radix 2 is always a candidate. A radix r in 3..RMAX (255 by default) is a candidate only when r < n0, which keeps r² within the padded length. The chosen radix is therefore 2, or lies between 3 and n0−1.
- R4: `cost` is unsigned with 16 fraction bits. It equals pad·2^16 + floor(K(r)·N·M·gamma / 2^8). Here gamma is unsigned with 16 fraction bits. K(r) = floor(BETA_Q8 · isqrt(r³·2^16) / 2^8) is the weight-scaled r·sqrt(r) with 8 fraction bits, and BETA_Q8 = 4019 (15.7·256).
- R5: The selected radix has the lowest cost of all candidates. On equal cost, the smaller radix is kept.
- R6: For n0 = 171 and gamma = 66 (about 0.001), the result is radix 3, padded length 243, 5 stages and 72 padding samples.
- R7: For n0 of 0 or 1, the result is `invalid` = 1, radix 2, padded length 2, 1 stage, padding 0 and cost 0. For any n0 ≥ 2, `invalid` is 0.
- R8: `start` is taken only while `busy` is low. `busy` stays high for the whole search. `done` is a one-cycle pulse with the results, and the results hold until the next search ends.
- R9: A `start` pulse while `busy` is high has no effect. The running search ends with the result for the inputs it was started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a search when idle |
| n0 | input | 16 | Requested transform length |
| gamma | input | 16 | Run-time weight, unsigned with 16 fraction bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, results valid |
| invalid | output | 1 | Requested length was below two |
| radix | output | 8 | Selected radix |
| padded_len | output | 24 | Padded transform length r^M |
| stages | output | 5 | Stage count M |
| pad_cnt | output | 24 | Number of zero samples added |
| cost | output | 70 | Cost of the winner, 16 fraction bits |

## Verification
The bench targets the smallest lengths. At n0 = 2 and n0 = 3 only radix 2 is legal. A design with a loose candidate bound would return radix 3 or a one-stage result, and a design without the length check would report a length of 0 or 1 as valid. Ties are forced with a zero weight and n0 = 64, where radices 2, 4 and 8 all give zero padding. A compare that replaces on equal cost would return 8. Several lengths and weights, from zero to the largest, are checked against an independent cost model, so a wrong table entry, fraction shift or stage count shows up as a wrong radix or cost. A `start` pulse during a search checks that a controller which re-latches its inputs would return the wrong length's answer.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_POWER,
        ST_COST,
        ST_COMPARE,
        ST_DONE
    } rsel_state_t;

    // Bitwise integer square root, floor result.
    function automatic logic [23:0] rsel_isqrt(input logic [47:0] x);
        logic [47:0] rem;
        logic [47:0] root;
        logic [47:0] bitv;
        rem  = x;
        root = '0;
        bitv = 48'h1 << 46;
        for (int i = 0; i < 24; i++) begin
            if (rem >= root + bitv) begin
                rem  = rem - root - bitv;
                root = (root >> 1) + bitv;
            end else begin
                root = root >> 1;
            end
            bitv = bitv >> 2;
        end
        return root[23:0];
    endfunction

    // Weighted r*sqrt(r), 8 fraction bits.
    function automatic logic [63:0] rsel_kcoef(input int r, input int beta_q8);
        logic [63:0] cube;
        logic [63:0] root;
        cube = 64'(r) * 64'(r) * 64'(r);
        root = 64'(rsel_isqrt(48'(cube << 16)));
        return (64'(beta_q8) * root) >> 8;
    endfunction

endpackage

// File: rtl/rsel_ktab.sv
module rsel_ktab #(
    parameter int RW      = 8,
    parameter int RMAX    = 255,
    parameter int BETA_Q8 = 4019,
    parameter int KW      = 32
) (
    input  logic [RW-1:0] r,
    output logic [KW-1:0] k
);
    localparam int DEPTH = 2 ** RW;

    logic [KW-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [63:0] KFULL =
            (g >= 2 && g <= RMAX) ? rsel_pkg::rsel_kcoef(g, BETA_Q8) : 64'd0;
        assign rom[g] = KFULL[KW-1:0];
    end

    assign k = rom[r];

endmodule

// File: rtl/rsel_power.sv
module rsel_power #(
    parameter int N0W = 16,
    parameter int RW  = 8,
    parameter int NW  = 24,
    parameter int MW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           run,
    input  logic [RW-1:0]  r,
    input  logic [N0W-1:0] target,
    output logic [NW-1:0]  power,
    output logic [MW-1:0]  stages,
    output logic           reached,
    output logic           overflow
);
    logic [NW+RW-1:0] prod;

    assign prod    = {{RW{1'b0}}, power} * {{NW{1'b0}}, r};
    assign reached = (power >= NW'(target));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power    <= '0;
            stages   <= '0;
            overflow <= 1'b0;
        end else if (load) begin
            power    <= NW'(1);
            stages   <= '0;
            overflow <= 1'b0;
        end else if (run && !reached && !overflow) begin
            if (prod[NW+RW-1:NW] != '0) begin
                overflow <= 1'b1;
            end else begin
                power  <= prod[NW-1:0];
                stages <= stages + 1'b1;
            end
        end
    end

    // R2
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !reached && !overflow) |=> (overflow || power > $past(power)));

    // R2
    stage_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stages <= MW'(N0W)));

endmodule

// File: rtl/rsel_cost.sv
module rsel_cost #(
    parameter int KW = 32,
    parameter int NW = 24,
    parameter int MW = 5,
    parameter int GW = 16,
    parameter int CW = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [KW-1:0] k,
    input  logic [NW-1:0] n,
    input  logic [MW-1:0] m,
    input  logic [NW-1:0] pad,
    input  logic [GW-1:0] gamma,
    output logic          valid,
    output logic [CW-1:0] cost
);
    localparam int P1W = KW + NW;
    localparam int P2W = P1W + MW;
    localparam int P3W = P2W + GW;

    logic [P1W-1:0] p1;
    logic [P2W-1:0] p2;
    logic [P3W-1:0] p3;
    logic [2:0]     vpipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1    <= '0;
            p2    <= '0;
            p3    <= '0;
            vpipe <= '0;
        end else begin
            p1    <= P1W'(k) * P1W'(n);
            p2    <= P2W'(p1) * P2W'(m);
            p3    <= P3W'(p2) * P3W'(gamma);
            vpipe <= {vpipe[1:0], go};
        end
    end

    assign valid = vpipe[2];
    assign cost  = (CW'(pad) << 16) + CW'(p3 >> 8);

    // R4
    cost_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(go, 3));

endmodule

// File: rtl/radix_cost_sel.sv
module radix_cost_sel #(
    parameter int N0W     = 16,
    parameter int GW      = 16,
    parameter int RMAX    = 255,
    parameter int BETA_Q8 = 4019,
    localparam int RW     = $clog2(RMAX + 1),
    localparam int NW     = N0W + RW,
    localparam int MW     = $clog2(N0W + 1),
    localparam int KW     = 32,
    localparam int CW     = KW + NW + MW + GW - 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N0W-1:0] n0,
    input  logic [GW-1:0]  gamma,
    output logic           busy,
    output logic           done,
    output logic           invalid,
    output logic [RW-1:0]  radix,
    output logic [NW-1:0]  padded_len,
    output logic [MW-1:0]  stages,
    output logic [NW-1:0]  pad_cnt,
    output logic [CW-1:0]  cost
);
    import rsel_pkg::*;

    rsel_state_t state, state_nx;

    logic [N0W-1:0] n0_q;
    logic [GW-1:0]  gamma_q;
    logic [RW-1:0]  r_q;

    logic [RW-1:0]  best_r;
    logic [NW-1:0]  best_n;
    logic [MW-1:0]  best_m;
    logic [NW-1:0]  best_pad;
    logic [CW-1:0]  best_cost;
    logic           best_inv;

    logic [KW-1:0]  k_val;
    logic [NW-1:0]  pw;
    logic [MW-1:0]  pm;
    logic           pw_reached;
    logic           pw_ovf;
    logic           pw_load;
    logic           pw_run;
    logic           cost_go;
    logic           cost_vld;
    logic [CW-1:0]  cand_cost;
    logic [NW-1:0]  cand_pad;
    logic           last_cand;
    logic           start_bad;

    assign start_bad = (n0 < N0W'(2));
    assign cand_pad  = pw - NW'(n0_q);
    assign last_cand = (int'(r_q) == RMAX) || (int'(r_q) + 1 >= int'(n0_q));
    assign pw_load   = (state == ST_LOAD);
    assign pw_run    = (state == ST_POWER);
    assign cost_go   = (state == ST_POWER) && pw_reached && !pw_ovf;
    assign busy      = (state != ST_IDLE);

    rsel_ktab #(
        .RW(RW), .RMAX(RMAX), .BETA_Q8(BETA_Q8), .KW(KW)
    ) u_ktab (
        .r(r_q),
        .k(k_val)
    );

    rsel_power #(
        .N0W(N0W), .RW(RW), .NW(NW), .MW(MW)
    ) u_power (
        .clk(clk),
        .rst_n(rst_n),
        .load(pw_load),
        .run(pw_run),
        .r(r_q),
        .target(n0_q),
        .power(pw),
        .stages(pm),
        .reached(pw_reached),
        .overflow(pw_ovf)
    );

    rsel_cost #(
        .KW(KW), .NW(NW), .MW(MW), .GW(GW), .CW(CW)
    ) u_cost (
        .clk(clk),
        .rst_n(rst_n),
        .go(cost_go),
        .k(k_val),
        .n(pw),
        .m(pm),
        .pad(cand_pad),
        .gamma(gamma_q),
        .valid(cost_vld),
        .cost(cand_cost)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = start_bad ? ST_DONE : ST_LOAD;
            end
            ST_LOAD: state_nx = ST_POWER;
            ST_POWER: begin
                if (pw_ovf)          state_nx = ST_COMPARE;
                else if (pw_reached) state_nx = ST_COST;
            end
            ST_COST: begin
                if (cost_vld) state_nx = ST_COMPARE;
            end
            ST_COMPARE: state_nx = last_cand ? ST_DONE : ST_LOAD;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n0_q      <= '0;
            gamma_q   <= '0;
            r_q       <= RW'(2);
            best_r    <= '0;
            best_n    <= '0;
            best_m    <= '0;
            best_pad  <= '0;
            best_cost <= '0;
            best_inv  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                n0_q    <= n0;
                gamma_q <= gamma;
                r_q     <= RW'(2);
                best_r  <= RW'(2);
                best_pad <= '0;
                if (start_bad) begin
                    best_n    <= NW'(2);
                    best_m    <= MW'(1);
                    best_cost <= '0;
                    best_inv  <= 1'b1;
                end else begin
                    best_n    <= '0;
                    best_m    <= '0;
                    best_cost <= '1;
                    best_inv  <= 1'b0;
                end
            end
            if (state == ST_COMPARE) begin
                if (!pw_ovf && cand_cost < best_cost) begin
                    best_r    <= r_q;
                    best_n    <= pw;
                    best_m    <= pm;
                    best_pad  <= cand_pad;
                    best_cost <= cand_cost;
                end
                if (!last_cand) r_q <= r_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            invalid    <= 1'b0;
            radix      <= '0;
            padded_len <= '0;
            stages     <= '0;
            pad_cnt    <= '0;
            cost       <= '0;
        end else begin
            done <= (state == ST_DONE);
            if (state == ST_DONE) begin
                invalid    <= best_inv;
                radix      <= best_r;
                padded_len <= best_n;
                stages     <= best_m;
                pad_cnt    <= best_pad;
                cost       <= best_cost;
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    invalid_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (radix == RW'(2) && padded_len == NW'(2)
                               && stages == MW'(1) && pad_cnt == '0));

    // R2
    pad_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !invalid) |-> (padded_len == pad_cnt + NW'(n0_q)));

    // R3
    radix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !invalid) |-> (radix == RW'(2)
                                || (radix > RW'(2) && int'(radix) < int'(n0_q))));

    // R5
    best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE && $past(state) != ST_DONE)
            |-> (best_cost <= $past(best_cost)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(n0_q));

endmodule

// File: tb/radix_cost_sel_test.sv
`timescale 1ns/1ps
module radix_cost_sel_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  n0 = '0;
    logic [15:0]  gamma = '0;
    logic         busy, done, invalid;
    logic [7:0]   radix;
    logic [23:0]  padded_len, pad_cnt;
    logic [4:0]   stages;
    logic [69:0]  cost;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    radix_cost_sel uut (
        .clk(clk), .rst_n(rst_n), .start(start), .n0(n0), .gamma(gamma),
        .busy(busy), .done(done), .invalid(invalid), .radix(radix),
        .padded_len(padded_len), .stages(stages), .pad_cnt(pad_cnt), .cost(cost)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint kref(input int r);
        longint x, s;
        x = longint'(r) * r * r * 65536;
        s = longint'($floor($sqrt(real'(x))));
        while (s * s > x) s--;
        while ((s + 1) * (s + 1) <= x) s++;
        return (4019 * s) >>> 8;
    endfunction

    function automatic void model(input int a, input int g,
                                  output int er, output longint en, output int em,
                                  output longint ep, output logic [127:0] ec);
        er = 2; en = 2; em = 1; ep = 0; ec = '0;
        if (a < 2) return;
        ec = '1;
        for (int r = 2; r <= 255; r++) begin
            longint pw;
            int m;
            logic [127:0] c;
            if (r > 2 && r >= a) break;
            pw = 1;
            m  = 0;
            while (pw < a) begin pw = pw * r; m++; end
            c = (128'(pw - a) << 16)
              + ((128'(kref(r)) * 128'(pw) * 128'(m) * 128'(g)) >> 8);
            if (c < ec) begin
                ec = c; er = r; en = pw; em = m; ep = pw - a;
            end
        end
    endfunction

    task automatic run(input int a, input int g, output bit ok);
        int cyc;
        @(negedge clk);
        n0 = 16'(a); gamma = 16'(g); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
        ok = done;
        if (!ok) begin
            n_tests++; n_fail++;
            $display("FAIL R8 no done for n0=%0d: got 0 expected 1", a);
        end
    endtask

    task automatic check_model(input int a, input int g);
        int er, em; longint en, ep; logic [127:0] ec; bit ok;
        run(a, g, ok);
        if (!ok) return;
        model(a, g, er, en, em, ep, ec);
        chk("R5", "radix", 128'(radix), 128'(er));
        chk("R2", "padded_len", 128'(padded_len), 128'(en));
        chk("R2", "stages", 128'(stages), 128'(em));
        chk("R2", "pad_cnt", 128'(pad_cnt), 128'(ep));
        chk("R4", "cost", 128'(cost), ec);
        chk("R7", "invalid", 128'(invalid), (a < 2) ? 128'd1 : 128'd0);
    endtask

    task automatic t_reset;
        chk("R1", "done", 128'(done), 0);
        chk("R1", "busy", 128'(busy), 0);
        chk("R1", "invalid", 128'(invalid), 0);
        chk("R1", "radix", 128'(radix), 0);
        chk("R1", "padded_len", 128'(padded_len), 0);
        chk("R1", "stages", 128'(stages), 0);
        chk("R1", "pad_cnt", 128'(pad_cnt), 0);
        chk("R1", "cost", 128'(cost), 0);
    endtask

    task automatic t_example;
        bit ok;
        run(171, 66, ok);
        if (!ok) return;
        chk("R6", "radix", 128'(radix), 3);
        chk("R6", "padded_len", 128'(padded_len), 243);
        chk("R6", "stages", 128'(stages), 5);
        chk("R6", "pad_cnt", 128'(pad_cnt), 72);
        check_model(171, 66);
    endtask

    task automatic t_invalid;
        bit ok;
        for (int a = 0; a < 2; a++) begin
            run(a, 66, ok);
            if (!ok) continue;
            chk("R7", "invalid", 128'(invalid), 1);
            chk("R7", "radix", 128'(radix), 2);
            chk("R7", "padded_len", 128'(padded_len), 2);
            chk("R7", "stages", 128'(stages), 1);
            chk("R7", "pad_cnt", 128'(pad_cnt), 0);
            chk("R7", "cost", 128'(cost), 0);
        end
    endtask

    task automatic t_tiny;
        bit ok;
        run(2, 66, ok);
        if (ok) begin
            chk("R3", "radix n0=2", 128'(radix), 2);
            chk("R3", "padded_len n0=2", 128'(padded_len), 2);
            chk("R3", "stages n0=2", 128'(stages), 1);
            chk("R7", "invalid n0=2", 128'(invalid), 0);
        end
        run(3, 0, ok);
        if (ok) begin
            chk("R3", "radix n0=3", 128'(radix), 2);
            chk("R3", "padded_len n0=3", 128'(padded_len), 4);
            chk("R3", "stages n0=3", 128'(stages), 2);
            chk("R3", "pad_cnt n0=3", 128'(pad_cnt), 1);
        end
    endtask

    task automatic t_tie;
        bit ok;
        run(64, 0, ok);
        if (ok) begin
            chk("R5", "tie radix", 128'(radix), 2);
            chk("R5", "tie stages", 128'(stages), 6);
            chk("R5", "tie cost", 128'(cost), 0);
        end
        run(1000, 0, ok);
        if (ok) begin
            chk("R5", "pad-only radix", 128'(radix), 10);
            chk("R5", "pad-only pad", 128'(pad_cnt), 0);
            chk("R5", "pad-only stages", 128'(stages), 3);
        end
    endtask

    task automatic t_sweep;
        check_model(65535, 65535);
        check_model(65535, 66);
        check_model(1000, 655);
        check_model(257, 1);
        check_model(5000, 66);
        check_model(17, 20000);
    endtask

    task automatic t_busy_start;
        int cyc;
        @(negedge clk);
        n0 = 16'd171; gamma = 16'd66; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8", "busy mid-run", 128'(busy), 1);
        n0 = 16'd1000; gamma = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 30000) begin @(negedge clk); cyc++; end
        chk("R9", "done seen", 128'(done), 1);
        chk("R9", "radix", 128'(radix), 3);
        chk("R9", "pad_cnt", 128'(pad_cnt), 72);
        chk("R8", "busy at done", 128'(busy), 0);
        @(negedge clk);
        chk("R8", "done width", 128'(done), 0);
        repeat (3) @(negedge clk);
        chk("R8", "radix held", 128'(radix), 3);
        chk("R8", "padded_len held", 128'(padded_len), 243);
        chk("R8", "still idle", 128'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_invalid();
        t_tiny();
        t_tie();
        t_sweep();
        t_busy_start();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog expired: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule